// File: doc/BRIEF.md
# Multiplexed ADC Bus-Interface Sequencer

This block is the digital front of a four-channel, 8-bit data converter that hangs off a microprocessor bus. The host runs a bus read: it pulls an active-low chip select and an active-low read strobe and presents a 2-bit channel address. That read starts a conversion. The conversion is modelled as a fixed number of clock cycles. At its end the value on the selected sample port is stored as the result. The sample ports stand in for the analog inputs. The block reports completion on an active-low interrupt. In stall mode it also holds the host through an open-drain ready pull-down.

A mode input picks one of two bus protocols. In stall mode the host read is held open until the result exists, and then the new result is driven. In pipelined mode the host never waits. Each read returns the result of the previous conversion, and the end of the read starts the next one, on the channel address captured when the read strobe rises. The chip select, read and address inputs each pass through a two-flop synchroniser before any edge is detected.

Top module: `adc_bus_seq`

## Requirements
- R1: After reset, dataOe is 0, intN is 1, rdyPullDn is 0, overrun is 0 and the stored result is zero.
- R2: A read is accepted when chipSelN and readN are both seen low while no conversion is pending or running. The conversion then lasts CONV_CYCLES clock cycles.
- R3: With modeSel=0 (stall), dataOe stays 0 during the conversion. When it ends, dataOut drives the byte on sampleIn bits [8c+7:8c], where c is chanAddr at that moment. dataOe stays 1 until the read ends.
- R4: With modeSel=0, rdyPullDn asserts after chipSelN falls and releases when the conversion ends.
- R5: intN goes low when a conversion completes. It returns high after a rising edge of chipSelN or readN.
- R6: With modeSel=1 (pipelined), an accepted read drives the previously stored result on dataOut with dataOe=1 until the read ends. The first read after reset returns 0.
- R7: With modeSel=1, chanAddr is captured on the rising edge of readN, and the conversion runs from that edge. Later address changes do not affect that conversion.
- R8: With modeSel=1, rdyPullDn is never asserted.
- R9: A read that starts while a conversion is pending or running is ignored: it gets no data drive and causes no restart. It sets overrun, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chipSelN | input | 1 | Active-low chip select (asynchronous) |
| readN | input | 1 | Active-low read strobe (asynchronous) |
| chanAddr | input | 2 | Channel address (asynchronous) |
| modeSel | input | 1 | 0 = stall mode, 1 = pipelined mode |
| sampleIn | input | 32 | Four 8-bit samples, channel c at bits [8c+7:8c] |
| dataOut | output | 8 | Result byte |
| dataOe | output | 1 | Output enable for dataOut (1 = bus driven) |
| intN | output | 1 | Active-low conversion-complete interrupt |
| rdyPullDn | output | 1 | Enable for the open-drain ready pull-down |
| overrun | output | 1 | Sticky flag: a read arrived while busy |

## Verification
The bench builds the block with CONV_CYCLES set to 6 instead of the default 12. That keeps each conversion shorter than the bench's waits, so many reads fit in one run. It also lets the bench start a second read while the first conversion is still running, which is how the overrun case is reached. The two modes are mixed at random from read to read, so a pipelined read often returns a result that a stall-mode read stored. Addresses are changed after a pipelined read ends, to show that the captured channel is the one converted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef struct packed {
    logic latchChan;   // capture synchronised address into channel register
    logic loadResult;  // store selected sample as result
    logic useLive;     // select from live synchronised address (stall mode)
  } seqStrobes_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stageQ[s] <= RST_VAL;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s > 0) ? s - 1 : 0];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chipSelN,
  input  logic        readN,
  input  logic        modeSel,
  output seqStrobes_t strobes,
  output logic        dataOe,
  output logic        intN,
  output logic        rdyPullDn,
  output logic        overrun
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [1:0] busS;
  logic csS, rdS, csPrev, rdPrev;
  logic readAct, readWas, readStart, readEnd, csRise, csFall, rdRise;
  logic busy, pendPipe, intFlag, rdyLow, oeQ, ovrQ, done, accept;
  logic [CNT_W-1:0] cnt;

  sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_busSync (
    .clk(clk), .rst_n(rst_n), .asyncIn({chipSelN, readN}), .syncOut(busS)
  );
  assign csS = busS[1];
  assign rdS = busS[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      csPrev <= csS;
      rdPrev <= rdS;
    end
  end

  assign readAct   = !csS && !rdS;
  assign readWas   = !csPrev && !rdPrev;
  assign readStart = readAct && !readWas;
  assign readEnd   = !readAct && readWas;
  assign csRise    = csS && !csPrev;
  assign csFall    = !csS && csPrev;
  assign rdRise    = rdS && !rdPrev;
  assign done      = busy && (cnt == '0);
  assign accept    = readStart && !busy && !pendPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pendPipe <= 1'b0;
      cnt      <= '0;
      intFlag  <= 1'b0;
      rdyLow   <= 1'b0;
      oeQ      <= 1'b0;
      ovrQ     <= 1'b0;
    end else begin
      if (readStart && !accept) ovrQ <= 1'b1;

      if (busy) cnt <= cnt - 1'b1;
      if (done) busy <= 1'b0;

      if (accept) begin
        if (modeSel) begin
          pendPipe <= 1'b1;
          oeQ      <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= CNT_LOAD;
        end
      end

      if (pendPipe && rdRise) begin
        pendPipe <= 1'b0;
        busy     <= 1'b1;
        cnt      <= CNT_LOAD;
      end

      if (!modeSel && csFall) rdyLow <= 1'b1;

      if (done) begin
        intFlag <= 1'b1;
        rdyLow  <= 1'b0;
        if (!modeSel && readAct) oeQ <= 1'b1;
      end else if (csRise || rdRise) begin
        intFlag <= 1'b0;
      end

      if (readEnd) oeQ <= 1'b0;
    end
  end

  assign strobes.latchChan  = pendPipe && rdRise;
  assign strobes.loadResult = done;
  assign strobes.useLive    = !modeSel;

  assign dataOe    = oeQ;
  assign intN      = !intFlag;
  assign rdyPullDn = rdyLow;
  assign overrun   = ovrQ;
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NUM_CH)-1:0] chanAddr,
  input  logic [NUM_CH*DATA_W-1:0] sampleIn,
  input  seqStrobes_t              strobes,
  output logic [DATA_W-1:0]        dataOut
);
  localparam int AW = $clog2(NUM_CH);

  logic [AW-1:0] addrS, chanQ, selChan;
  logic [DATA_W-1:0] resultQ, picked;

  sync_chain #(.WIDTH(AW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addrSync (
    .clk(clk), .rst_n(rst_n), .asyncIn(chanAddr), .syncOut(addrS)
  );

  assign selChan = strobes.useLive ? addrS : chanQ;

  always_comb begin
    picked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (selChan == AW'(c)) picked = sampleIn[c*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chanQ   <= '0;
      resultQ <= '0;
    end else begin
      if (strobes.latchChan) chanQ <= addrS;
      if (strobes.loadResult) resultQ <= picked;
    end
  end

  assign dataOut = resultQ;
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 12,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chipSelN,
  input  logic                      readN,
  input  logic [$clog2(NUM_CH)-1:0] chanAddr,
  input  logic                      modeSel,
  input  logic [NUM_CH*DATA_W-1:0]  sampleIn,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      dataOe,
  output logic                      intN,
  output logic                      rdyPullDn,
  output logic                      overrun
);
  seqStrobes_t strobes;

  adc_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chipSelN(chipSelN), .readN(readN),
    .modeSel(modeSel), .strobes(strobes), .dataOe(dataOe), .intN(intN),
    .rdyPullDn(rdyPullDn), .overrun(overrun)
  );

  adc_seq_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .chanAddr(chanAddr), .sampleIn(sampleIn),
    .strobes(strobes), .dataOut(dataOut)
  );
endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeSel,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              intN,
  input logic              rdyPullDn,
  input logic              overrun
);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R4
  oe_ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> !rdyPullDn);

  // R8
  pipe_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeSel |-> !rdyPullDn);

  // R3
  stall_drive_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeSel && dataOe) |-> !intN);

  // R6
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |=> (!dataOe || $stable(dataOut)));
endmodule

bind adc_bus_seq adc_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_adc_bus_seq.sv
module tb_adc_bus_seq;
  localparam int CONV = 6;
  localparam int NCH = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipSelN = 1'b1, readN = 1'b1, modeSel = 1'b0;
  logic [1:0] chanAddr = '0;
  logic [NCH*DW-1:0] sampleIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOe, intN, rdyPullDn, overrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] expPrev;

  adc_bus_seq #(.CONV_CYCLES(CONV), .NUM_CH(NCH), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .chipSelN(chipSelN), .readN(readN),
    .chanAddr(chanAddr), .modeSel(modeSel), .sampleIn(sampleIn),
    .dataOut(dataOut), .dataOe(dataOe), .intN(intN),
    .rdyPullDn(rdyPullDn), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pickSample(logic [NCH*DW-1:0] v, logic [1:0] c);
    return v[c*DW +: DW];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stallRead(logic [1:0] ch);
    modeSel = 1'b0;
    chanAddr = ch;
    sampleIn = {$urandom, $urandom} [NCH*DW-1:0];
    chipSelN = 1'b0;
    waitCyc(4);
    check("R4 ready pulled after select falls", rdyPullDn, 1);
    readN = 1'b0;
    waitCyc(CONV);
    check("R3 bus idle during conversion", dataOe, 0);
    waitCyc(6);
    check("R3 bus driven at end", dataOe, 1);
    check("R3 stall result", dataOut, pickSample(sampleIn, ch));
    check("R4 ready released", rdyPullDn, 0);
    check("R5 interrupt low", intN, 0);
    expPrev = pickSample(sampleIn, ch);
    readN = 1'b1;
    chipSelN = 1'b1;
    waitCyc(5);
    check("R5 interrupt cleared by rise", intN, 1);
    check("R3 bus released", dataOe, 0);
  endtask

  task automatic pipeRead(logic [1:0] ch);
    logic [NCH*DW-1:0] snap;
    modeSel = 1'b1;
    chanAddr = ch;
    chipSelN = 1'b0;
    readN = 1'b0;
    waitCyc(5);
    check("R6 pipelined drive", dataOe, 1);
    check("R6 previous result", dataOut, expPrev);
    check("R8 no ready", rdyPullDn, 0);
    readN = 1'b1;
    chipSelN = 1'b1;
    waitCyc(5);
    chanAddr = ch + 2'd1;  // R7: change after capture
    snap = {$urandom, $urandom} [NCH*DW-1:0];
    sampleIn = snap;
    waitCyc(CONV + 2);
    check("R5 interrupt at completion", intN, 0);
    check("R6 bus released", dataOe, 0);
    expPrev = pickSample(snap, ch);
    sampleIn = {$urandom, $urandom} [NCH*DW-1:0];
  endtask

  initial begin
    void'($urandom(32'd4242));
    expPrev = '0;
    waitCyc(3);
    check("R1 reset oe", dataOe, 0);
    check("R1 reset int", intN, 1);
    check("R1 reset ready", rdyPullDn, 0);
    check("R1 reset overrun", overrun, 0);
    rst_n = 1'b1;
    waitCyc(2);

    // R6: first pipelined read returns zero; R7 capture checked on next read
    pipeRead(2'd2);
    pipeRead(2'd1);
    stallRead(2'd3);
    pipeRead(2'd0);

    for (int i = 0; i < 24; i++) begin
      logic [1:0] ch;
      ch = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) pipeRead(ch);
      else stallRead(ch);
    end

    // R2/R9: read during running conversion is ignored and flagged
    modeSel = 1'b1;
    chanAddr = 2'd3;
    chipSelN = 1'b0;
    readN = 1'b0;
    waitCyc(5);
    check("R6 pre-overrun data", dataOut, expPrev);
    readN = 1'b1;
    chipSelN = 1'b1;
    sampleIn = {8'hA5, 8'h11, 8'h22, 8'h33};
    waitCyc(3);
    chanAddr = 2'd0;
    chipSelN = 1'b0;
    readN = 1'b0;
    waitCyc(4);
    check("R9 busy read not driven", dataOe, 0);
    check("R9 overrun set", overrun, 1);
    readN = 1'b1;
    chipSelN = 1'b1;
    waitCyc(CONV + 8);
    check("R9 overrun sticky", overrun, 1);
    expPrev = 8'hA5;
    pipeRead(2'd1);
    check("R9 no restart on ignored read", overrun, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule